// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches a single active-low interrupt pin from outside the chip and raises an interrupt request toward the CPU. The pin is asynchronous, so it passes through a synchronizer before any detection. A falling edge on the synchronized pin sets a pending latch. The CPU services that latch through one byte-wide status and control register. The register exposes the pending state and lets the CPU acknowledge the request, mask the request output, and choose how the pin triggers.

There are two trigger modes. In edge mode only a falling edge sets the latch, so a pin that stays low raises one request. In level mode a low pin also counts as a request. The latch therefore stays set for as long as the pin is held low, and it is cleared only by an acknowledge written after the pin has gone high again. The mask blocks only the request output. The pending flag still shows the latch, so software can poll the pin with the request masked.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset with the pin high, the register reads 0x00, the request output is 0, and no request appears while the pin stays high. The synchronizer stages reset to the high level.
- R2: Register bits 7..4 and bit 2 always read 0. Writing 1 to bits 7..4 has no effect on the value read back.
- R3: Bit 1 (mask) and bit 0 (mode) are stored by a write and read back. Both reset to 0.
- R4: In mode 0, the register reads bit 3 (pending) = 1 three clock edges after the pin input falls, and not after two. A pin that stays low after an acknowledge does not set pending again.
- R5: In mode 1, pending is set while the synchronized pin is low, and an acknowledge written then does not clear it. An acknowledge written after the pin has returned high clears it.
- R6: A write with bit 2 = 1 clears pending when no new trigger occurs in that cycle. A write with bit 2 = 0 leaves pending unchanged.
- R7: When a falling edge is detected in the same cycle as an acknowledge write, pending stays 1.
- R8: Pending reads the latch whatever the mask is. The request output is 1 exactly when pending is 1 and mask is 0.
- R9: When the read strobe is low, the read data bus is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Asynchronous external interrupt pin, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (bit 3 pending, bit 1 mask, bit 0 mode, others 0) |
| irq_req | output | 1 | Interrupt request to the CPU, active high |

## Verification
A latch that is stuck, or that misses a trigger, shows up within three cycles as a wrong bit 3 on a read and a wrong request output. A synchronizer that is one stage short or long moves the first change in pending by one cycle, and the latency checks catch this. A wrong priority between set and clear in the latch shows up on the acknowledge cycle itself: pending reads wrong on the very next read after a collision, or after an acknowledge made while the pin is still low in level mode. A stored mask or mode bit that is wrong shows up on the next read. It also shows up as a request output that does not follow pending.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int REG_W   = 8;
    localparam int BIT_PND = 3;
    localparam int BIT_ACK = 2;
    localparam int BIT_MSK = 1;
    localparam int BIT_MOD = 0;

    typedef struct packed {
        logic pend;
        logic mask;
        logic mode;
    } ctrl_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] stg_d, stg_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb stg_d = din;
        end else begin : g_many
            always_comb stg_d = {stg_q[TOP-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '1;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[TOP];
endmodule

// File: rtl/irq_fall_det.sv
module irq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             lvl,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             pend,
    output logic             mask,
    output logic             mode,
    output logic             irq_req
);
    ctrl_state_t st_d, st_q;
    logic        trig;
    logic        ack;
    logic [REG_W-1:0] view;

    always_comb begin
        st_d = st_q;
        trig = fall | (st_q.mode & ~lvl);
        ack  = wr_en & wdata[BIT_ACK];
        if (trig)     st_d.pend = 1'b1;
        else if (ack) st_d.pend = 1'b0;
        if (wr_en) begin
            st_d.mask = wdata[BIT_MSK];
            st_d.mode = wdata[BIT_MOD];
        end
        view          = '0;
        view[BIT_PND] = st_q.pend;
        view[BIT_MSK] = st_q.mask;
        view[BIT_MOD] = st_q.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata   = rd_en ? view : '0;
    assign pend    = st_q.pend;
    assign mask    = st_q.mask;
    assign mode    = st_q.mode;
    assign irq_req = st_q.pend & ~st_q.mask;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             irq_req
);
    logic sync_lvl;
    logic fall;
    logic pend;
    logic mask;
    logic mode;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_n),
        .dout (sync_lvl)
    );

    irq_fall_det u_fdet (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (sync_lvl),
        .fall (fall)
    );

    irq_ctrl_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall   (fall),
        .lvl    (sync_lvl),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .pend   (pend),
        .mask   (mask),
        .mode   (mode),
        .irq_req(irq_req)
    );
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sync_lvl,
    input logic       fall,
    input logic       pend,
    input logic       mask,
    input logic       mode,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       irq_req
);
    a_r4_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> pend);

    a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !sync_lvl) |=> pend);

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[2] && !fall && !(mode && !sync_lvl)) |=> !pend);

    a_r7_edge_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && wr_en && wdata[2]) |=> pend);

    a_r8_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq_req);

    a_r2_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[7:4] == 4'h0) && !rdata[2]);

    a_r9_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == 8'h00));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_lvl(sync_lvl),
    .fall    (fall),
    .pend    (pend),
    .mask    (mask),
    .mode    (mode),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rd_en   (rd_en),
    .rdata   (rdata),
    .irq_req (irq_req)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic m_s1, m_s2, m_prev, m_pend, m_mask, m_mode;

    always #5 clk = ~clk;

    ext_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_req(irq_req)
    );

    function automatic logic [7:0] exp_rd();
        return rd_en ? {4'h0, m_pend, 1'b0, m_mask, m_mode} : 8'h00;
    endfunction

    function automatic logic exp_irq();
        return m_pend & ~m_mask;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_s1 = 1; m_s2 = 1; m_prev = 1; m_pend = 0; m_mask = 0; m_mode = 0;
    endtask

    task automatic model_clock();
        logic f, t, a;
        f = m_prev & ~m_s2;
        t = f | (m_mode & ~m_s2);
        a = wr_en & wdata[2];
        if (t) m_pend = 1;
        else if (a) m_pend = 0;
        if (wr_en) begin
            m_mask = wdata[1];
            m_mode = wdata[0];
        end
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_n;
    endtask

    // drive at negedge, advance one clock, return at next negedge
    task automatic step(input logic p, input logic w, input logic [7:0] d, input logic r);
        pin_n = p; wr_en = w; wdata = d; rd_en = r;
        @(posedge clk);
        model_clock();
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic cmp(input string tag);
        chk(tag, rdata, exp_rd());
        chk({tag, " irq"}, {7'h0, irq_req}, {7'h0, exp_irq()});
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 reset rdata", rdata, 8'h00);
        chk("R1 reset irq", {7'h0, irq_req}, 8'h00);
        repeat (5) step(1, 0, 8'h00, 1);
        chk("R1 idle high no request", rdata, 8'h00);

        // R3 mask and mode store, R2 upper bits ignored
        step(1, 1, 8'hF3, 1);
        chk("R2 R3 write F3 reads 03", rdata, 8'h03);
        step(1, 1, 8'h00, 1);
        chk("R3 write 00 reads 00", rdata, 8'h00);

        // R9 idle bus
        step(1, 0, 8'h00, 0);
        step(1, 1, 8'h03, 0);
        chk("R9 rd low bus zero", rdata, 8'h00);
        rd_en = 1; #1;
        chk("R3 read back 03", rdata, 8'h03);
        step(1, 1, 8'h00, 1);

        // R4 edge latency, mode 0
        step(0, 0, 8'h00, 1);
        step(0, 0, 8'h00, 1);
        chk("R4 not after two edges", rdata, 8'h00);
        step(0, 0, 8'h00, 1);
        chk("R4 pending after three", rdata, 8'h08);
        chk("R8 irq unmasked", {7'h0, irq_req}, 8'h01);
        // R8 mask keeps pending visible
        step(0, 1, 8'h02, 1);
        chk("R8 masked pending shows", rdata, 8'h0A);
        chk("R8 masked irq low", {7'h0, irq_req}, 8'h00);
        // R6 write without ack leaves pending
        step(0, 1, 8'h00, 1);
        chk("R6 no-ack write keeps pending", rdata, 8'h08);
        // R6/R4 ack clears, low pin does not re-set in mode 0
        step(0, 1, 8'h04, 1);
        chk("R6 ack clears", rdata, 8'h00);
        repeat (4) step(0, 0, 8'h00, 1);
        chk("R4 sustained low no re-set", rdata, 8'h00);
        repeat (3) step(1, 0, 8'h00, 1);

        // R7 edge and ack collide: pin falls, two edges later fall is seen
        step(0, 0, 8'h00, 1);
        step(0, 0, 8'h00, 1);
        step(0, 1, 8'h04, 1);
        chk("R7 collision keeps pending", rdata, 8'h08);
        step(0, 1, 8'h04, 1);
        chk("R6 later ack clears", rdata, 8'h00);
        repeat (3) step(1, 0, 8'h00, 1);

        // R5 level mode
        step(1, 1, 8'h01, 1);
        repeat (3) step(0, 0, 8'h00, 1);
        chk("R5 level sets", rdata, 8'h09);
        step(0, 1, 8'h05, 1);
        chk("R5 ack while low ignored", rdata, 8'h09);
        repeat (3) step(1, 0, 8'h00, 1);
        chk("R5 still pending after high", rdata, 8'h09);
        step(1, 1, 8'h05, 1);
        chk("R5 ack after high clears", rdata, 8'h01);
        step(1, 1, 8'h00, 1);

        // random phase against model
        for (int i = 0; i < 3000; i++) begin
            logic p, w, r;
            logic [7:0] d;
            p = ($urandom_range(0, 7) == 0) ? ~pin_n : pin_n;
            w = ($urandom_range(0, 5) == 0);
            d = 8'($urandom());
            r = ($urandom_range(0, 9) != 0);
            step(p, w, d, r);
            cmp("R8 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule